// File: doc/BRIEF.md
# Set-Clear Interrupt Status Unit

This block gathers condition flags from a transmit FIFO and a receive FIFO into a sticky status register and drives one interrupt line. Four flags follow FIFO levels. Two of them compare a level against a watermark that software can program. The other two are pulse events, overflow and underflow, which are held until software clears them. Software clears status bits by writing ones to them.

Each source can be allowed to raise the interrupt. This is done through two write-only ports. One port turns sources on and the other turns them off. The resulting mask can only be read. The FIFOs and the bus address decode are outside this block: the bus side presents one write strobe per register and a shared data word.

Top module: `irq_status_unit`

## Requirements
- R1: After reset the status and the mask are all zero and `irq` is low.
- R2: Status bit 2 (TX low) is set in the cycle after any cycle in which `txLevel` is below the TX watermark. This bit is not set in a cycle in which it is being cleared.
- R3: Status bit 3 (TX full) is set in the cycle after any cycle in which `txLevel` equals `DEPTH`. This bit is not set in a cycle in which it is being cleared.
- R4: Status bit 4 (RX ready) is set in the cycle after any cycle in which `rxLevel` is at or above the RX watermark. With a watermark of 1 this bit means the RX FIFO is not empty.
- R5: Status bit 5 (RX full) is set in the cycle after any cycle in which `rxLevel` equals `DEPTH`.
- R6: Status bit 0 is set by `rxOverflowPulse` and status bit 6 is set by `txUnderflowPulse`. Each stays set until it is cleared. A pulse that arrives in the same cycle as its clear leaves the bit set.
- R7: A status write clears exactly the bits written as one and leaves all other bits unchanged. A level bit whose condition still holds reads 0 in the cycle after the clear and reads 1 again one cycle later.
- R8: Writing ones to the enable port sets the matching mask bits. Writing ones to the disable port clears them. When both ports are written in the same cycle, disable wins.
- R9: `irq` is high exactly when some status bit is set and its mask bit is also set.
- R10: Bit 1 and bits 31 to 7 of the status and of the mask always read zero, even when ones are written to those bits.
- R11: Both watermarks are loaded from the low bits of `wrData` by their own strobes and can be read back. They reset to `RX_MARK_RST` and `TX_MARK_RST`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wrStatus | input | 1 | Write-one-to-clear strobe for the status register |
| wrEnable | input | 1 | Strobe that sets mask bits |
| wrDisable | input | 1 | Strobe that clears mask bits |
| wrRxMark | input | 1 | Load strobe for the RX watermark |
| wrTxMark | input | 1 | Load strobe for the TX watermark |
| wrData | input | WR_W | Write data shared by all strobes |
| txLevel | input | LVL_W | Number of entries in the TX FIFO |
| rxLevel | input | LVL_W | Number of entries in the RX FIFO |
| rxOverflowPulse | input | 1 | One-cycle event: RX FIFO overflow |
| txUnderflowPulse | input | 1 | One-cycle event: TX FIFO underflow |
| statusOut | output | 32 | Status register read value |
| maskOut | output | 32 | Mask register read value |
| rxMarkOut | output | LVL_W | RX watermark read value |
| txMarkOut | output | LVL_W | TX watermark read value |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check four rules on every cycle:
- an event bit persists until it is cleared;
- a cleared TX-full bit is really low in the following cycle, and a full FIFO sets the bit again otherwise;
- a disabled mask bit drops;
- reserved bits stay zero, and `irq` stays quiet while the mask is empty.

Some properties can only be shown by the bench scenarios:
- the exact watermark comparisons, which the bench sweeps over every level and watermark pair;
- the priority between a clear and an event that arrive together;
- the reappearance of a level bit two cycles after its clear;
- the disable-over-enable rule.

// File: rtl/irq_status_pkg.sv
package irq_status_pkg;
  localparam int SRC_W = 7;
  localparam int BIT_RX_OVF   = 0;
  localparam int BIT_TX_LOW   = 2;
  localparam int BIT_TX_FULL  = 3;
  localparam int BIT_RX_READY = 4;
  localparam int BIT_RX_FULL  = 5;
  localparam int BIT_TX_UNF   = 6;
  localparam logic [SRC_W-1:0] LIVE_BITS = 7'b111_1101;

  typedef struct packed {
    logic [SRC_W-1:0] clrBits;
    logic [SRC_W-1:0] setMaskBits;
    logic [SRC_W-1:0] dropMaskBits;
    logic             loadRxMark;
    logic             loadTxMark;
  } ctrl_strobe_t;
endpackage

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import irq_status_pkg::*;
(
  input  logic                   wrStatus,
  input  logic                   wrEnable,
  input  logic                   wrDisable,
  input  logic                   wrRxMark,
  input  logic                   wrTxMark,
  input  logic [SRC_W-1:0]       bitData,
  output ctrl_strobe_t           strobes
);
  logic [SRC_W-1:0] liveData;
  assign liveData = bitData & LIVE_BITS;

  always_comb begin
    strobes              = '0;
    strobes.clrBits      = wrStatus  ? liveData : '0;
    strobes.setMaskBits  = wrEnable  ? liveData : '0;
    strobes.dropMaskBits = wrDisable ? liveData : '0;
    strobes.loadRxMark   = wrRxMark;
    strobes.loadTxMark   = wrTxMark;
  end
endmodule

// File: rtl/irq_status_datapath.sv
module irq_status_datapath
  import irq_status_pkg::*;
#(
  parameter int DEPTH       = 63,
  parameter int RX_MARK_RST = 32,
  parameter int TX_MARK_RST = 1,
  localparam int LVL_W      = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctrl_strobe_t     strobes,
  input  logic [LVL_W-1:0] markData,
  input  logic [LVL_W-1:0] txLevel,
  input  logic [LVL_W-1:0] rxLevel,
  input  logic             rxOverflowPulse,
  input  logic             txUnderflowPulse,
  output logic [SRC_W-1:0] statusQ,
  output logic [SRC_W-1:0] maskQ,
  output logic [LVL_W-1:0] rxMarkQ,
  output logic [LVL_W-1:0] txMarkQ
);
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

  logic [SRC_W-1:0] levelSet;
  logic [SRC_W-1:0] eventSet;
  logic [SRC_W-1:0] statusNext;
  logic [SRC_W-1:0] maskNext;

  always_comb begin
    levelSet               = '0;
    levelSet[BIT_TX_LOW]   = txLevel < txMarkQ;
    levelSet[BIT_TX_FULL]  = txLevel == FULL_LVL;
    levelSet[BIT_RX_READY] = rxLevel >= rxMarkQ;
    levelSet[BIT_RX_FULL]  = rxLevel == FULL_LVL;
    eventSet               = '0;
    eventSet[BIT_RX_OVF]   = rxOverflowPulse;
    eventSet[BIT_TX_UNF]   = txUnderflowPulse;
  end

  // A clear beats a level condition for one cycle, but never drops a new event.
  assign statusNext = ((statusQ | levelSet) & ~strobes.clrBits) | eventSet;
  assign maskNext   = (maskQ | strobes.setMaskBits) & ~strobes.dropMaskBits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      statusQ <= '0;
      maskQ   <= '0;
      rxMarkQ <= LVL_W'(RX_MARK_RST);
      txMarkQ <= LVL_W'(TX_MARK_RST);
    end else begin
      statusQ <= statusNext;
      maskQ   <= maskNext;
      if (strobes.loadRxMark) rxMarkQ <= markData;
      if (strobes.loadTxMark) txMarkQ <= markData;
    end
  end

  assert_event_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (statusQ[BIT_RX_OVF] && !strobes.clrBits[BIT_RX_OVF]) |=> statusQ[BIT_RX_OVF]);

  assert_clear_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.clrBits[BIT_TX_FULL] |=> !statusQ[BIT_TX_FULL]);

  assert_full_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (txLevel == FULL_LVL && !strobes.clrBits[BIT_TX_FULL]) |=> statusQ[BIT_TX_FULL]);

  for (genvar k = 0; k < SRC_W; k++) begin : g_maskChk
    assert_mask_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
      strobes.dropMaskBits[k] |=> !maskQ[k]);
  end
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
  import irq_status_pkg::*;
#(
  parameter int DEPTH       = 63,
  parameter int RX_MARK_RST = 32,
  parameter int TX_MARK_RST = 1,
  localparam int LVL_W      = $clog2(DEPTH + 1),
  localparam int WR_W       = (LVL_W > SRC_W) ? LVL_W : SRC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wrStatus,
  input  logic             wrEnable,
  input  logic             wrDisable,
  input  logic             wrRxMark,
  input  logic             wrTxMark,
  input  logic [WR_W-1:0]  wrData,
  input  logic [LVL_W-1:0] txLevel,
  input  logic [LVL_W-1:0] rxLevel,
  input  logic             rxOverflowPulse,
  input  logic             txUnderflowPulse,
  output logic [31:0]      statusOut,
  output logic [31:0]      maskOut,
  output logic [LVL_W-1:0] rxMarkOut,
  output logic [LVL_W-1:0] txMarkOut,
  output logic             irq
);
  ctrl_strobe_t     strobes;
  logic [SRC_W-1:0] statusBits;
  logic [SRC_W-1:0] maskBits;

  irq_status_ctrl i_ctrl (
    .wrStatus (wrStatus),
    .wrEnable (wrEnable),
    .wrDisable(wrDisable),
    .wrRxMark (wrRxMark),
    .wrTxMark (wrTxMark),
    .bitData  (wrData[SRC_W-1:0]),
    .strobes  (strobes)
  );

  irq_status_datapath #(
    .DEPTH      (DEPTH),
    .RX_MARK_RST(RX_MARK_RST),
    .TX_MARK_RST(TX_MARK_RST)
  ) i_datapath (
    .clk             (clk),
    .rst_n           (rst_n),
    .strobes         (strobes),
    .markData        (wrData[LVL_W-1:0]),
    .txLevel         (txLevel),
    .rxLevel         (rxLevel),
    .rxOverflowPulse (rxOverflowPulse),
    .txUnderflowPulse(txUnderflowPulse),
    .statusQ         (statusBits),
    .maskQ           (maskBits),
    .rxMarkQ         (rxMarkOut),
    .txMarkQ         (txMarkOut)
  );

  assign statusOut = {{(32 - SRC_W){1'b0}}, statusBits};
  assign maskOut   = {{(32 - SRC_W){1'b0}}, maskBits};
  assign irq       = |(statusBits & maskBits);

  assert_reserved_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (statusOut[31:7] == '0) && !statusOut[1] && (maskOut[31:7] == '0) && !maskOut[1]);

  assert_irq_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (maskOut == '0) |-> !irq);
endmodule

// File: tb/test_irq_status_unit.sv
`timescale 1ns/1ps
module test_irq_status_unit;
  localparam int DEPTH = 7;
  localparam int LVL_W = 3;
  localparam int WR_W  = 7;

  logic clk = 0;
  logic rst_n = 0;
  logic wrStatus = 0, wrEnable = 0, wrDisable = 0, wrRxMark = 0, wrTxMark = 0;
  logic [WR_W-1:0]  wrData = '0;
  logic [LVL_W-1:0] txLevel = '0, rxLevel = '0;
  logic rxOverflowPulse = 0, txUnderflowPulse = 0;
  logic [31:0] statusOut, maskOut;
  logic [LVL_W-1:0] rxMarkOut, txMarkOut;
  logic irq;
  int tests = 0;
  int fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  irq_status_unit #(.DEPTH(DEPTH), .RX_MARK_RST(4), .TX_MARK_RST(1)) i_irq_status_unit (
    .clk(clk), .rst_n(rst_n), .wrStatus(wrStatus), .wrEnable(wrEnable),
    .wrDisable(wrDisable), .wrRxMark(wrRxMark), .wrTxMark(wrTxMark),
    .wrData(wrData), .txLevel(txLevel), .rxLevel(rxLevel),
    .rxOverflowPulse(rxOverflowPulse), .txUnderflowPulse(txUnderflowPulse),
    .statusOut(statusOut), .maskOut(maskOut), .rxMarkOut(rxMarkOut),
    .txMarkOut(txMarkOut), .irq(irq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] levelExp(int tl, int tm, int rl, int rm);
    logic [31:0] r = '0;
    r[2] = tl < tm;
    r[3] = tl == DEPTH;
    r[4] = rl >= rm;
    r[5] = rl == DEPTH;
    return r;
  endfunction

  task automatic pulseWrite(int sel, logic [WR_W-1:0] d);
    @(negedge clk);
    wrData = d;
    case (sel)
      0: wrStatus = 1;
      1: wrEnable = 1;
      2: wrDisable = 1;
      3: wrRxMark = 1;
      default: wrTxMark = 1;
    endcase
    @(negedge clk);
    wrStatus = 0; wrEnable = 0; wrDisable = 0; wrRxMark = 0; wrTxMark = 0;
  endtask

  // Apply levels, clear all, check the clear cycle, then the settled status.
  task automatic settle(int tl, int rl, logic [31:0] exp, string req);
    @(negedge clk);
    txLevel = LVL_W'(tl); rxLevel = LVL_W'(rl);
    @(negedge clk);
    wrStatus = 1; wrData = 7'h7F;
    @(negedge clk);
    check("R7 clear cycle", statusOut, 32'h0);
    wrStatus = 0;
    @(negedge clk);
    check(req, statusOut, exp);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      fails++;
      tests++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 status", statusOut, 0);
    check("R1 mask", maskOut, 0);
    check("R1 irq", {31'b0, irq}, 0);
    check("R11 rx mark reset", {29'b0, rxMarkOut}, 4);
    check("R11 tx mark reset", {29'b0, txMarkOut}, 1);
    rst_n = 1;

    // R2 R3 sweep: every TX level against every TX watermark
    pulseWrite(3, 7'd4);
    for (int tm = 0; tm <= DEPTH; tm++) begin
      pulseWrite(4, WR_W'(tm));
      check("R11 tx mark readback", {29'b0, txMarkOut}, tm);
      for (int tl = 0; tl <= DEPTH; tl++)
        settle(tl, 0, levelExp(tl, tm, 0, 4), "R2 R3 tx level sweep");
    end

    // R4 R5 sweep: every RX level against every RX watermark
    pulseWrite(4, 7'd1);
    for (int rm = 0; rm <= DEPTH; rm++) begin
      pulseWrite(3, WR_W'(rm));
      check("R11 rx mark readback", {29'b0, rxMarkOut}, rm);
      for (int rl = 0; rl <= DEPTH; rl++)
        settle(3, rl, levelExp(3, 1, rl, rm), "R4 R5 rx level sweep");
    end

    // R6 events: quiet levels first
    pulseWrite(3, 7'd1);
    settle(3, 0, 32'h0, "R6 quiet base");
    @(negedge clk); rxOverflowPulse = 1;
    @(negedge clk); rxOverflowPulse = 0;
    repeat (3) @(negedge clk);
    check("R6 overflow held", statusOut, 32'h01);
    wrStatus = 1; wrData = 7'h41; txUnderflowPulse = 1;
    @(negedge clk);
    wrStatus = 0; txUnderflowPulse = 0;
    check("R6 event beats clear", statusOut, 32'h40);
    @(negedge clk);
    check("R6 underflow held", statusOut, 32'h40);
    pulseWrite(0, 7'h40);
    check("R6 cleared", statusOut, 32'h0);

    // R7 selective clear and level reappearance
    settle(0, DEPTH, 32'h34, "R7 base");
    @(negedge clk); wrStatus = 1; wrData = 7'h04;
    @(negedge clk); wrStatus = 0;
    check("R7 only bit2 cleared", statusOut, 32'h30);
    @(negedge clk);
    check("R7 level bit returns", statusOut, 32'h34);

    // R8 R10 mask
    pulseWrite(1, 7'h7F);
    check("R8 R10 enable all", maskOut, 32'h7D);
    pulseWrite(2, 7'h05);
    check("R8 disable", maskOut, 32'h78);
    @(negedge clk); wrEnable = 1; wrDisable = 1; wrData = 7'h08;
    @(negedge clk); wrEnable = 0; wrDisable = 0;
    check("R8 disable wins", maskOut, 32'h70);

    // R9 interrupt
    check("R9 irq high", {31'b0, irq}, 1);
    pulseWrite(2, 7'h30);
    check("R9 mask left", maskOut, 32'h40);
    check("R9 irq low", {31'b0, irq}, 0);
    @(negedge clk); txUnderflowPulse = 1;
    @(negedge clk); txUnderflowPulse = 0;
    check("R9 irq on event", {31'b0, irq}, 1);
    pulseWrite(0, 7'h40);
    check("R9 irq after clear", {31'b0, irq}, 0);
    check("R10 reserved status", statusOut & 32'hFFFF_FF82, 0);

    // R11 watermark loads
    pulseWrite(3, 7'd5);
    check("R11 rx mark", {29'b0, rxMarkOut}, 5);
    pulseWrite(4, 7'd6);
    check("R11 tx mark", {29'b0, txMarkOut}, 6);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule